// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

This block is a serial port with four software-selected operating modes. Mode 0 is a synchronous 8-bit shifter that drives its own shift clock at one sixth of the system clock. Mode 1 is an asynchronous 8-bit UART. Modes 2 and 3 are asynchronous 9-bit UARTs. Mode 2 runs at a fixed fraction of the system clock, and mode 3 runs from an external 16x baud tick. Software reaches the block through a small register bus: one control/status byte and one data byte. A write to the data byte starts a transmission. Received bytes are read back through the data byte.

The asynchronous modes oversample the line 16 times per bit and read each bit at its centre. For multiprocessor links, an address-filter bit can hold back the receive flag. In the 9-bit modes it does so when the received ninth bit is 0. In mode 1 it does so when the stop bit is invalid. The transmit and receive flags are raised by hardware at points that depend on the mode. Only a software write clears them. The receive line passes through a two-stage synchronizer before any logic sees it.

Top module: `sio_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the receive buffer reads 0x00, `txd` is 1 and `sclk` is 1.
- R2: The control byte is laid out from bit 7 down to bit 0 as: mode high, mode low, address filter, receive enable, transmit ninth bit, receive ninth bit, transmit flag, receive flag. It is read and written whole with `sel`=0. With `sel`=1, a read returns the receive buffer and a write starts a transmission.
- R3: The mode code is {bit7,bit6}: 00 selects the shifter, 01 the 8-bit UART, 10 the fixed-rate 9-bit UART and 11 the tick-rate 9-bit UART. An asynchronous frame is a 0 start bit, 8 data bits LSB first, the transmit ninth bit in modes 2 and 3 only, and a 1 stop bit. The line goes low on the clock after the data write.
- R4: Mode 2 holds each bit for 16 clocks when `div32_sel`=0 and for 32 clocks when `div32_sel`=1. Modes 1 and 3 hold each bit for 16 `baud_tick` pulses.
- R5: In the asynchronous modes the transmit flag rises when the stop bit begins. That is 9 bit times after the write edge in mode 1 and 10 bit times after it in modes 2 and 3.
- R6: In mode 0 a data write shifts 8 bits out on `txd`, LSB first. Each bit lasts 6 clocks, with `sclk` low for 3 clocks and then high for 3. The transmit flag rises 48 clocks after the write edge.
- R7: In mode 0 a reception runs while receive enable is 1 and the receive flag is 0. It samples `rxd` once per rising `sclk` edge, LSB first, and sets the receive flag after the 8th bit. The receive ninth bit is left unchanged.
- R8: An accepted asynchronous frame loads the receive buffer and sets the receive flag halfway through the stop bit. The receive ninth bit takes the received ninth bit in modes 2 and 3 and the stop bit in mode 1.
- R9: In modes 2 and 3 with the address filter set, a frame whose ninth bit is 0 leaves the receive flag and the buffer unchanged.
- R10: In mode 1 with the address filter set, a 0 stop bit leaves the receive flag at 0. With the filter clear, the same frame is accepted and the receive ninth bit reads 0.
- R11: With receive enable at 0, no frame is received.
- R12: A low pulse on `rxd` that has gone high again by mid-bit is discarded as a false start.
- R13: Hardware only sets the two flags. They stay set until software writes 0 to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| sel | input | 1 | Register select: 0 control byte, 1 data byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| baud_tick | input | 1 | 16x bit-rate tick for modes 1 and 3 |
| div32_sel | input | 1 | Mode 2 divisor: 0 for /16, 1 for /32 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, mode 0 data out |
| sclk | output | 1 | Mode 0 shift clock, high when idle |

## Verification
A bad bit or tick counter in the transmitter shows up on `txd` within one bit time. It also moves the clock count at which the transmit flag rises away from 16 times the frame's bit position. A corrupt receive index or mid-bit point shows up when the frame completes, as a wrong buffer byte or ninth bit, or as a receive flag that rises too early or not at all. That is at most one frame time, about 160 to 330 clocks here. In mode 0 a wrong phase counter shows within one 6-clock bit, as a misplaced `sclk` edge or a flag that misses the 48-clock mark.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } sio_mode_e;

  // True for the modes that carry a ninth data bit.
  function automatic logic nine_bit_mode(input sio_mode_e m);
    return (m == MODE_UART9F) || (m == MODE_UART9V);
  endfunction

  // Multiprocessor address filter: decides whether a finished frame is kept.
  function automatic logic frame_kept(input sio_mode_e m, input logic filt,
                                      input logic b9, input logic stopb);
    if (!filt) return 1'b1;
    if (m == MODE_UART8) return stopb;
    return b9;
  endfunction

  // Value loaded into the receive ninth-bit field.
  function automatic logic rx_ninth(input sio_mode_e m, input logic b9, input logic stopb);
    return (m == MODE_UART8) ? stopb : b9;
  endfunction

endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sio_mode_e mode,
  input  logic      div32_sel,
  input  logic      baud_tick,
  output logic      tick
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  always_comb begin
    case (mode)
      MODE_UART9F:             tick = div32_sel ? half_q : 1'b1;
      MODE_UART8, MODE_UART9V: tick = baud_tick;
      default:                 tick = 1'b0;
    endcase
  end

  // R4
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UART9F && div32_sel && tick) |=> (!tick || mode != MODE_UART9F || !div32_sel));

endmodule

// File: rtl/sio_async_tx.sv
module sio_async_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          nine,
  input  logic          b9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          stop_ev
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          busy_q, nine_q;
  logic [IW-1:0] last_idx;
  logic          adv;

  assign last_idx = nine_q ? IW'(DW + 2) : IW'(DW + 1);
  assign adv      = busy_q && tick && (cnt_q == CW'(OVS - 1));
  assign stop_ev  = adv && (idx_q == last_idx - IW'(1));
  assign busy     = busy_q;
  assign txd      = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      nine_q <= 1'b0;
    end else if (start && !busy_q) begin
      sh_q   <= {1'b1, (nine ? b9 : 1'b1), data, 1'b0};
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b1;
      nine_q <= nine;
    end else if (busy_q && tick) begin
      cnt_q <= cnt_q + CW'(1);
      if (adv) begin
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        idx_q <= idx_q + IW'(1);
        if (idx_q == last_idx) busy_q <= 1'b0;
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (txd == 1'b0));
  // R5
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (txd == 1'b1));

endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          stopb,
  output logic          done_ev
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OVS / 2 - 1;

  logic          run_q, nine_q, rxd_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sh_q;
  logic [IW-1:0] last_idx;
  logic          mid_ev, false_ev;

  assign last_idx = nine_q ? IW'(DW + 2) : IW'(DW + 1);
  assign mid_ev   = run_q && en && tick && (cnt_q == CW'(MID));
  assign false_ev = mid_ev && (idx_q == '0) && rxd;
  assign done_ev  = mid_ev && (idx_q == last_idx);
  assign stopb    = rxd;
  assign data     = nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
  assign b9       = sh_q[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      nine_q <= 1'b0;
      rxd_q  <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      rxd_q <= rxd;
      if (!run_q) begin
        if (en && rxd_q && !rxd) begin
          run_q  <= 1'b1;
          nine_q <= nine;
          cnt_q  <= '0;
          idx_q  <= '0;
        end
      end else if (!en) begin
        run_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= cnt_q + CW'(1);
        if (false_ev || done_ev) run_q <= 1'b0;
        else if (mid_ev && idx_q != '0) sh_q <= {rxd, sh_q[DW:1]};
        if (cnt_q == CW'(OVS - 1)) idx_q <= idx_q + IW'(1);
      end
    end
  end

  // R12
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_ev |=> !run_q);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !run_q);

endmodule

// File: rtl/sio_shift0.sv
module sio_shift0 #(
  parameter int DW  = 8,
  parameter int DIV = 6
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] data,
  input  logic          rxd,
  output logic          txd,
  output logic          sclk,
  output logic [DW-1:0] rx_data,
  output logic          tx_done,
  output logic          rx_done,
  output logic          busy
);
  localparam int PW   = $clog2(DIV);
  localparam int BW   = $clog2(DW);
  localparam int HALF = DIV / 2;

  logic          busy_q, dir_tx_q;
  logic [PW-1:0] ph_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          bit_end, end_ev;

  assign bit_end = busy_q && (ph_q == PW'(DIV - 1));
  assign end_ev  = bit_end && (bit_q == BW'(DW - 1));
  assign tx_done = end_ev && dir_tx_q;
  assign rx_done = end_ev && !dir_tx_q;
  assign busy    = busy_q;
  assign sclk    = busy_q ? (ph_q >= PW'(HALF)) : 1'b1;
  assign txd     = (busy_q && dir_tx_q) ? sh_q[0] : 1'b1;
  assign rx_data = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_tx_q <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (!busy_q && (start_tx || start_rx)) begin
      busy_q   <= 1'b1;
      dir_tx_q <= start_tx;
      ph_q     <= '0;
      bit_q    <= '0;
      if (start_tx) sh_q <= data;
    end else if (busy_q) begin
      ph_q <= bit_end ? '0 : ph_q + PW'(1);
      if (!dir_tx_q && ph_q == PW'(HALF)) sh_q <= {rxd, sh_q[DW-1:1]};
      if (bit_end) begin
        if (end_ev) busy_q <= 1'b0;
        else        bit_q  <= bit_q + BW'(1);
        if (dir_tx_q) sh_q <= {1'b1, sh_q[DW-1:1]};
      end
    end
  end

  // R6
  m0_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (!busy_q || !sclk));
  // R7
  m0_rx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dir_tx_q) |-> txd);

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int OVS    = 16,
  parameter int M0_DIV = 6,
  parameter int SYNC_N = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       baud_tick,
  input  logic       div32_sel,
  input  logic       rxd,
  output logic       txd,
  output logic       sclk
);
  localparam int CTRL_W = 8;

  sio_mode_e   mode_q;
  logic        filt_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [DW-1:0] rbuf_q;
  logic [SYNC_N-1:0] sync_q;
  logic        rxd_s, ctrl_wr, data_wr, is_m0;
  logic        tick, a_txd, a_busy, a_stop_ev;
  logic [DW-1:0] a_data, m0_data;
  logic        a_b9, a_stopb, a_done, rx_accept;
  logic        m0_txd, m0_tx_done, m0_rx_done, m0_busy;

  assign ctrl_wr = wr_en && !sel;
  assign data_wr = wr_en && sel;
  assign is_m0   = (mode_q == MODE_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_N-1];

  sio_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .div32_sel(div32_sel),
    .baud_tick(baud_tick), .tick(tick)
  );

  sio_async_tx #(.DW(DW), .OVS(OVS)) u_atx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(data_wr && !is_m0),
    .nine(nine_bit_mode(mode_q)), .b9(tb8_q), .data(wdata[DW-1:0]),
    .txd(a_txd), .busy(a_busy), .stop_ev(a_stop_ev)
  );

  sio_async_rx #(.DW(DW), .OVS(OVS)) u_arx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ren_q && !is_m0),
    .nine(nine_bit_mode(mode_q)), .rxd(rxd_s), .data(a_data), .b9(a_b9),
    .stopb(a_stopb), .done_ev(a_done)
  );

  sio_shift0 #(.DW(DW), .DIV(M0_DIV)) u_m0 (
    .clk(clk), .rst_n(rst_n), .start_tx(data_wr && is_m0),
    .start_rx(is_m0 && ren_q && !ri_q && !data_wr), .data(wdata[DW-1:0]),
    .rxd(rxd_s), .txd(m0_txd), .sclk(sclk), .rx_data(m0_data),
    .tx_done(m0_tx_done), .rx_done(m0_rx_done), .busy(m0_busy)
  );

  assign rx_accept = a_done && frame_kept(mode_q, filt_q, a_b9, a_stopb);
  assign txd       = is_m0 ? m0_txd : a_txd;
  assign rdata     = sel ? CTRL_W'(rbuf_q)
                         : {mode_q, filt_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SHIFT;
      filt_q <= 1'b0;
      ren_q  <= 1'b0;
      tb8_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rbuf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= sio_mode_e'(wdata[7:6]);
        filt_q <= wdata[5];
        ren_q  <= wdata[4];
        tb8_q  <= wdata[3];
        rb8_q  <= wdata[2];
        ti_q   <= wdata[1];
        ri_q   <= wdata[0];
      end
      if (a_stop_ev || m0_tx_done) ti_q <= 1'b1;
      if (rx_accept) begin
        ri_q   <= 1'b1;
        rbuf_q <= a_data;
        rb8_q  <= rx_ninth(mode_q, a_b9, a_stopb);
      end
      if (m0_rx_done) begin
        ri_q   <= 1'b1;
        rbuf_q <= m0_data;
      end
    end
  end

  // R13
  ti_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ti_q) |-> $past(ctrl_wr));
  // R13
  ri_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri_q) |-> $past(ctrl_wr));
  // R11
  rx_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> ren_q);
  // R9
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_done && filt_q && nine_bit_mode(mode_q) && !a_b9 && !m0_busy) |=> $stable(rbuf_q));
  // R5
  ti_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti_q) && !$past(ctrl_wr)) |-> $past(a_busy || m0_busy));

endmodule

// File: tb/sim_sio_ctrl.sv
`timescale 1ns/100ps
module sim_sio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sel = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic baud_tick = 1'b1, div32_sel = 1'b0, rxd, txd, sclk;
  logic loop_en = 1'b0, rx_drv = 1'b1, slow = 1'b0;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  sio_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .baud_tick(baud_tick), .div32_sel(div32_sel), .rxd(rxd),
    .txd(txd), .sclk(sclk));

  initial forever begin
    @(negedge clk);
    baud_tick = slow ? ~baud_tick : 1'b1;
  end

  typedef struct packed {
    logic [1:0] mode; logic filt; logic ren; logic tb8; logic slw;
    logic [7:0] data; logic exp_ri; logic exp_rb8;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h96, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0; sel = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    sel = s;
    #0.5 v = rdata;
    sel = 1'b0;
    #0.1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopb);
    @(negedge clk) rx_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = d[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = stopb;
    repeat (16) @(negedge clk);
    rx_drv = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, prev_buf, got;
    int n, exp_n, per, bits;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(1'b0, v); chk(v == 8'h00, "R1", "ctrl", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1", "rbuf", v, 0);
    chk(txd == 1'b1, "R1", "txd", txd, 1);
    chk(sclk == 1'b1, "R1", "sclk", sclk, 1);

    // R2 control layout read back, then R13 software clear
    wr(1'b0, 8'h2F); rd(1'b0, v); chk(v == 8'h2F, "R2", "ctrl readback", v, 8'h2F);
    wr(1'b0, 8'h00); rd(1'b0, v); chk(v == 8'h00, "R13", "sw clear", v, 0);

    // Table walk: loopback frames in the asynchronous modes
    loop_en = 1'b1;
    foreach (VEC[k]) begin
      vec_t t = VEC[k];
      slow = t.slw; div32_sel = t.slw;
      rd(1'b1, prev_buf);
      wr(1'b0, {t.mode, t.filt, t.ren, t.tb8, 3'b000});
      repeat (3) @(posedge clk);
      wr(1'b1, t.data);
      chk(txd == 1'b0, "R3", "start bit", txd, 0);
      n = 0;
      while (n < 4000) begin
        @(posedge clk); n++;
        #1 if (rdata[1]) break;
      end
      bits = (t.mode == 2'd1) ? 9 : 10;
      per = t.slw ? 32 : 16;
      exp_n = bits * per;
      // R4 / R5: flag at the start of the stop bit
      chk((n >= exp_n - 1) && (n <= exp_n + 1) && (t.slw || n == exp_n), "R5", "ti delay", n, exp_n);
      chk(rdata[0] == 1'b0, "R8", "ri before mid-stop", rdata[0], 0);
      repeat (per * 2) @(posedge clk);
      #1 rd(1'b0, v);
      chk(v[1] == 1'b1, "R13", "ti held", v[1], 1);
      chk(v[0] == t.exp_ri, t.ren ? (t.exp_ri ? "R8" : "R9") : "R11", "ri", v[0], t.exp_ri);
      rd(1'b1, got);
      if (t.exp_ri) begin
        chk(got == t.data, "R3", "rbuf", got, t.data);
        chk(v[2] == t.exp_rb8, "R8", "rb8", v[2], t.exp_rb8);
      end else begin
        chk(got == prev_buf, t.ren ? "R9" : "R11", "rbuf unchanged", got, prev_buf);
      end
    end
    loop_en = 1'b0; slow = 1'b0; div32_sel = 1'b0;

    // R10 mode 1 filter on bad stop bit
    wr(1'b0, 8'h70);
    send_frame(8'h69, 1'b0);
    rd(1'b0, v); chk(v[0] == 1'b0, "R10", "ri with bad stop, filter on", v[0], 0);
    wr(1'b0, 8'h54);
    send_frame(8'h3C, 1'b0);
    rd(1'b0, v); chk(v[0] == 1'b1, "R10", "ri with bad stop, filter off", v[0], 1);
    chk(v[2] == 1'b0, "R10", "rb8 = stop", v[2], 0);
    rd(1'b1, got); chk(got == 8'h3C, "R10", "rbuf", got, 8'h3C);

    // R12 false start
    wr(1'b0, 8'h90);
    rd(1'b1, prev_buf);
    @(negedge clk) rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (300) @(posedge clk);
    #1 rd(1'b0, v); chk(v[0] == 1'b0, "R12", "ri after glitch", v[0], 0);
    rd(1'b1, got); chk(got == prev_buf, "R12", "rbuf after glitch", got, prev_buf);

    // R6 mode 0 transmit
    wr(1'b0, 8'h00);
    begin
      logic sp; int bc; logic [7:0] cap;
      sp = 1'b1; bc = 0; cap = 8'h00;
      wr(1'b1, 8'hB4);
      n = 0;
      while (n < 200) begin
        @(posedge clk); n++;
        #1;
        if (sclk && !sp && bc < 8) begin cap[bc] = txd; bc++; end
        sp = sclk;
        if (rdata[1]) break;
      end
      chk(n == 48, "R6", "ti delay", n, 48);
      chk(cap == 8'hB4, "R6", "shifted byte", cap, 8'hB4);
      chk(bc == 8, "R6", "sclk rises", bc, 8);
    end

    // R7 mode 0 receive, rb8 left at 1
    begin
      logic [7:0] pat; logic sp; int bc;
      pat = 8'h6D; sp = 1'b1; bc = 0;
      rx_drv = pat[0];
      wr(1'b0, 8'h14);
      n = 0;
      while (n < 200 && bc < 8) begin
        @(posedge clk); n++;
        #1;
        if (sclk && !sp) begin
          bc++;
          if (bc < 8) rx_drv = pat[bc];
        end
        sp = sclk;
      end
      repeat (6) @(posedge clk);
      #1 rd(1'b0, v);
      chk(v[0] == 1'b1, "R7", "ri", v[0], 1);
      chk(v[2] == 1'b1, "R7", "rb8 unchanged", v[2], 1);
      rd(1'b1, got); chk(got == pat, "R7", "rbuf", got, pat);
      rx_drv = 1'b1;
      wr(1'b0, 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule